// File: doc/BRIEF.md
# Audio DMA Address Generator

This block is the address engine of one bus-master channel that streams audio words between a sample FIFO and a circular buffer in system memory. Software writes a buffer start address, a protection address (start plus buffer size), a boundary code and a transfer shaping word, then starts the channel. The engine then walks a live byte address through the buffer, one 32-bit word per accepted transfer. It returns to the start address when the next address would equal the protection address.

Every time the live address lands on a multiple of a programmable power-of-two range, a sticky status bit is set so that software can refill or drain the buffer in fixed slices. The range is 2^(5+L) bytes for a 4-bit code L. A request/acknowledge pair stands in for the system bus. Requests are gated by a FIFO fill threshold and grouped into bursts of bounded length. The live address and the offset into the buffer are always visible on output ports.

Top module: `dma_audio_addrgen`

## Requirements
- R1: After reset the live address is 0, `dma_req` is low and `irq` is low; the channel is stopped and both the interrupt enable and the status bit are clear.
- R2: Register select 4 is the run control. A write sets run only when bit 16 (write mask) and bit 0 are both 1, and this also loads the live address with the start address. Bit 16 at 1 with bit 0 at 0 stops the channel. With bit 16 at 0 the write has no effect. While stopped, `dma_req` is low and `dma_ack` leaves the address unchanged.
- R3: Each clock edge on which `dma_req` and `dma_ack` are both high advances the live address by 4 bytes.
- R4: When the advanced address would equal the protection address (select 1), the live address becomes the start address (select 0) instead.
- R5: The page register (select 2) holds the boundary code L in bits 7:4. For L from 1 to 15, a transfer whose advanced, unwrapped address is a multiple of 2^(5+L) bytes sets the status bit. For L = 0 no transfer sets it.
- R6: The status bit is sticky and is cleared by writing 1 to bit 0 at select 6. A boundary hit in the same cycle as the clear leaves it set. `irq` is the status bit ANDed with the enable in bit 0 of select 5.
- R7: The threshold field is bits 5:4 of select 3, with codes 00, 01, 10 and 11 standing for 1, 4, 8 and 16 words. A new burst requests only when `fifo_level` is at least that count.
- R8: The burst field is bits 2:0 of select 3 and stands for 2^n words, from 1 to 128. Once a burst has moved its first word, `dma_req` stays high whatever the fill level until the burst's last word is accepted. After that, the threshold applies again.
- R9: `cur_offset` is the live address minus the start address. It reads 0 when that difference equals the protection address minus the start address.
- R10: Bit 11 of the page register (address translation flag) has no effect: addresses stay physical and follow R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 start, 1 protection, 2 page, 3 shaping, 4 run, 5 irq enable, 6 status) |
| wr_data | input | 32 | Register write data |
| fifo_level | input | LVL_W | Words available in the sample FIFO |
| dma_ack | input | 1 | Bus accepts the current word |
| dma_req | output | 1 | Word transfer request |
| dma_addr | output | 32 | Live byte address |
| cur_offset | output | 32 | Live offset into the buffer |
| irq | output | 1 | Gated boundary interrupt |

## Verification
A boundary hit and a software clear of the status bit can land on the same edge. The bench steps the channel with its model until the next accepted word will reach a range multiple. It then drives that acknowledge together with the clear write, and it expects `irq` to stay high. A wrap and a boundary hit also coincide, because the protection address is itself a range multiple. The scoreboard expects the address to return to the start and the status bit to be set on the same transfer.

// File: rtl/dma_addrgen_pkg.sv
package dma_addrgen_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_BYTES = 4;

  typedef enum logic [2:0] {
    SEL_START = 3'd0,
    SEL_PROT  = 3'd1,
    SEL_PAGE  = 3'd2,
    SEL_SHAPE = 3'd3,
    SEL_RUN   = 3'd4,
    SEL_IEN   = 3'd5,
    SEL_STAT  = 3'd6
  } reg_sel_e;

  // words per burst: 2^code
  function automatic logic [8:0] burst_words(input logic [2:0] code);
    return 9'd1 << code;
  endfunction

  // words needed in the FIFO before a burst starts
  function automatic logic [4:0] thresh_words(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // address sits on a 2^(5+lim) byte multiple; code 0 disables
  function automatic logic on_boundary(input logic [ADDR_W-1:0] a, input logic [3:0] lim);
    logic [ADDR_W-1:0] mask;
    if (lim == 4'd0) return 1'b0;
    mask = (ADDR_W'(1) << (5 + int'(lim))) - ADDR_W'(1);
    return (a & mask) == '0;
  endfunction

  function automatic logic [ADDR_W-1:0] buf_offset(input logic [ADDR_W-1:0] a,
                                                    input logic [ADDR_W-1:0] start,
                                                    input logic [ADDR_W-1:0] prot);
    logic [ADDR_W-1:0] d;
    d = a - start;
    return (d == prot - start) ? '0 : d;
  endfunction
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_addrgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              bnd_hit,
  output logic [ADDR_W-1:0] start_q,
  output logic [ADDR_W-1:0] prot_q,
  output logic [3:0]        lim_q,
  output logic [2:0]        burst_q,
  output logic [1:0]        thr_q,
  output logic              run_q,
  output logic              ien_q,
  output logic              stat_q,
  output logic              start_pulse,
  output logic              clr_pulse
);
  logic stop_pulse;

  assign start_pulse = wr_en && wr_sel == SEL_RUN && wr_data[16] && wr_data[0];
  assign stop_pulse  = wr_en && wr_sel == SEL_RUN && wr_data[16] && !wr_data[0];
  assign clr_pulse   = wr_en && wr_sel == SEL_STAT && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      prot_q  <= '0;
      lim_q   <= '0;
      burst_q <= '0;
      thr_q   <= '0;
      run_q   <= 1'b0;
      ien_q   <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_START: start_q <= wr_data[ADDR_W-1:0];
          SEL_PROT:  prot_q  <= wr_data[ADDR_W-1:0];
          SEL_PAGE:  lim_q   <= wr_data[7:4];
          SEL_SHAPE: begin
            burst_q <= wr_data[2:0];
            thr_q   <= wr_data[5:4];
          end
          SEL_IEN:   ien_q   <= wr_data[0];
          default: ;
        endcase
      end
      if (start_pulse)     run_q <= 1'b1;
      else if (stop_pulse) run_q <= 1'b0;
      if (bnd_hit)        stat_q <= 1'b1;
      else if (clr_pulse) stat_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_burst_pacer.sv
module dma_burst_pacer
  import dma_addrgen_pkg::*;
#(
  parameter int LVL_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [2:0]       burst_code,
  input  logic [1:0]       thr_code,
  input  logic             ack,
  output logic             req,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q;
  logic             level_ok;
  logic             last_word;

  assign level_ok  = fifo_level >= LVL_W'(thresh_words(thr_code));
  assign req       = run && (cnt_q != '0 || level_ok);
  assign fire      = req && ack;
  assign last_word = (9'(cnt_q) + 9'd1) == burst_words(burst_code);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)  cnt_q <= '0;
    else if (fire)       cnt_q <= last_word ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr
  import dma_addrgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fire,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] prot_addr,
  input  logic [3:0]        lim,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wrap_hit,
  output logic              bnd_hit
);
  logic [ADDR_W-1:0] nxt_raw;

  assign nxt_raw  = addr_q + ADDR_W'(WORD_BYTES);
  assign wrap_hit = fire && !start && nxt_raw == prot_addr;
  assign bnd_hit  = fire && !start && on_boundary(nxt_raw, lim);

  always_ff @(posedge clk) begin
    if (!rst_n)        addr_q <= '0;
    else if (start)    addr_q <= start_addr;
    else if (wrap_hit) addr_q <= start_addr;
    else if (fire)     addr_q <= nxt_raw;
  end
endmodule

// File: rtl/dma_audio_addrgen.sv
module dma_audio_addrgen
  import dma_addrgen_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             dma_ack,
  output logic             dma_req,
  output logic [31:0]      dma_addr,
  output logic [31:0]      cur_offset,
  output logic             irq
);
  logic [ADDR_W-1:0] start_q, prot_q, addr_q;
  logic [3:0]        lim_q;
  logic [2:0]        burst_q;
  logic [1:0]        thr_q;
  logic run_q, ien_q, stat_q, start_pulse, clr_pulse;
  logic xfer_fire, wrap_hit, bnd_hit;

  dma_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .bnd_hit(bnd_hit), .start_q(start_q), .prot_q(prot_q), .lim_q(lim_q),
    .burst_q(burst_q), .thr_q(thr_q), .run_q(run_q), .ien_q(ien_q), .stat_q(stat_q),
    .start_pulse(start_pulse), .clr_pulse(clr_pulse)
  );

  dma_burst_pacer #(.LVL_W(LVL_W), .CNT_W(8)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(run_q), .fifo_level(fifo_level),
    .burst_code(burst_q), .thr_code(thr_q), .ack(dma_ack),
    .req(dma_req), .fire(xfer_fire)
  );

  dma_addr_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .fire(xfer_fire),
    .start_addr(start_q), .prot_addr(prot_q), .lim(lim_q),
    .addr_q(addr_q), .wrap_hit(wrap_hit), .bnd_hit(bnd_hit)
  );

  assign dma_addr   = addr_q;
  assign cur_offset = buf_offset(addr_q, start_q, prot_q);
  assign irq        = stat_q && ien_q;
endmodule

// File: rtl/dma_addrgen_chk.sv
module dma_addrgen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dma_req,
  input logic        dma_ack,
  input logic [31:0] dma_addr,
  input logic        irq,
  input logic        run_q,
  input logic        stat_q,
  input logic        start_pulse,
  input logic        clr_pulse,
  input logic        wrap_hit,
  input logic        bnd_hit
);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack && !wrap_hit && !start_pulse) |=> dma_addr == $past(dma_addr) + 32'd4);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(dma_req && dma_ack) && !start_pulse) |=> $stable(dma_addr));

  assert_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !dma_req);

  assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_hit |=> stat_q);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr_pulse) |=> stat_q);

  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_q);
endmodule

bind dma_audio_addrgen dma_addrgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_ack(dma_ack),
  .dma_addr(dma_addr), .irq(irq), .run_q(run_q), .stat_q(stat_q),
  .start_pulse(start_pulse), .clr_pulse(clr_pulse),
  .wrap_hit(wrap_hit), .bnd_hit(bnd_hit)
);

// File: tb/dma_audio_addrgen_tb_top.sv
module dma_audio_addrgen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  fifo_level = '0;
  logic        dma_ack = 1'b0;
  logic        dma_req, irq;
  logic [31:0] dma_addr, cur_offset;

  typedef struct { logic [31:0] a; logic i; } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_addr, m_start, m_prot;
  int  m_lim = 0;
  logic m_stat = 0, m_ien = 0;

  always #5 clk = ~clk;

  dma_audio_addrgen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fifo_level(fifo_level), .dma_ack(dma_ack), .dma_req(dma_req),
    .dma_addr(dma_addr), .cur_offset(cur_offset), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // bench model of one accepted word
  function automatic bit model_step();
    logic [31:0] nxt = m_addr + 32'd4;
    bit hit = (m_lim != 0) && ((nxt % (32'd32 << m_lim)) == 0);
    m_addr = (nxt == m_prot) ? m_start : nxt;
    if (hit) m_stat = 1;
    return hit;
  endfunction

  task automatic xfer(bit clr = 0);
    @(negedge clk);
    check("R8 req before word", {31'd0, dma_req}, 32'd1);
    void'(model_step());
    sb.push_back('{m_addr, m_stat & m_ien});
    dma_ack = 1;
    if (clr) begin wr_en = 1; wr_sel = 3'd6; wr_data = 32'd1; end
    @(negedge clk); dma_ack = 0; wr_en = 0;
  endtask

  // monitor: compare each accepted word with the scoreboard
  initial forever begin
    bit took;
    @(posedge clk);
    took = dma_req && dma_ack;
    #1;
    if (took) begin
      exp_t e;
      if (sb.size() == 0) check("R3 scoreboard empty", 32'd1, 32'd0);
      else begin
        e = sb.pop_front();
        check("R3/R4 addr", dma_addr, e.a);
        check("R5/R6 irq", {31'd0, irq}, {31'd0, e.i});
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 addr", dma_addr, 0);
    check("R1 req", {31'd0, dma_req}, 0);
    check("R1 irq", {31'd0, irq}, 0);

    m_start = 32'h1000; m_prot = 32'h1100; m_lim = 1;
    wr(3'd0, m_start); wr(3'd1, m_prot); wr(3'd2, 32'h10);
    wr(3'd3, 32'h0); wr(3'd5, 32'h1); m_ien = 1;
    fifo_level = 16;
    wr(3'd4, 32'h1);                         // no mask: ignored
    check("R2 unmasked write", {31'd0, dma_req}, 0);
    wr(3'd4, 32'h10001);
    m_addr = m_start;
    check("R2 start loads addr", dma_addr, m_start);
    check("R2 req after start", {31'd0, dma_req}, 1);

    for (int k = 0; k < 20; k++) xfer();      // crosses 0x1040 (R5)
    check("R5 irq after boundary", {31'd0, irq}, 1);
    wr(3'd6, 32'h1); m_stat = 0;
    check("R6 clear", {31'd0, irq}, 0);
    check("R9 offset", cur_offset, m_addr - m_start);

    wr(3'd5, 32'h0); m_ien = 0;
    while (((m_addr + 4) % 64) != 0) xfer();
    xfer();
    check("R6 gated", {31'd0, irq}, 0);
    wr(3'd5, 32'h1); m_ien = 1;
    check("R6 sticky status shows", {31'd0, irq}, 1);
    wr(3'd6, 32'h1); m_stat = 0;

    // collision: boundary hit and clear on the same edge
    while (((m_addr + 4) % 64) != 0) xfer();
    xfer(1);
    check("R6 set beats clear", {31'd0, irq}, 1);
    wr(3'd6, 32'h1); m_stat = 0;

    // wrap (protection 0x1100 is also a boundary)
    while (m_addr != 32'h10FC) xfer();
    xfer();
    check("R4 wrapped to start", dma_addr, m_start);
    check("R4 wrap boundary irq", {31'd0, irq}, 1);
    wr(3'd6, 32'h1); m_stat = 0;

    // offset equal to buffer size reads 0
    xfer(); xfer();
    wr(3'd1, dma_addr);
    check("R9 offset at size", cur_offset, 0);
    wr(3'd1, m_prot);

    // code 0: no boundary interrupts
    wr(3'd2, 32'h0); m_lim = 0;
    for (int k = 0; k < 40; k++) xfer();
    check("R5 code 0 silent", {31'd0, irq}, 0);

    // translation flag ignored
    wr(3'd2, 32'h810); m_lim = 1;
    for (int k = 0; k < 20; k++) xfer();
    check("R10 flag ignored addr", dma_addr, m_addr);

    // thresholds and bursts (burst idle here: burst code 0)
    fifo_level = 0;
    wr(3'd3, 32'h32);                        // thr 16, burst 4
    fifo_level = 15; #1;
    check("R7 below 16", {31'd0, dma_req}, 0);
    fifo_level = 16; #1;
    check("R7 at 16", {31'd0, dma_req}, 1);
    fifo_level = 0;
    wr(3'd3, 32'h12);                        // thr 4, burst 4
    fifo_level = 3; #1;
    check("R7 below 4", {31'd0, dma_req}, 0);
    fifo_level = 4; #1;
    check("R7 at 4", {31'd0, dma_req}, 1);
    xfer();
    fifo_level = 0;
    xfer(); xfer(); xfer();                  // burst continues (R8)
    @(negedge clk);
    check("R8 burst ended", {31'd0, dma_req}, 0);

    // stop: ack ignored
    fifo_level = 16;
    wr(3'd4, 32'h10000);
    check("R2 stopped req", {31'd0, dma_req}, 0);
    @(negedge clk); dma_ack = 1; @(negedge clk); dma_ack = 0;
    check("R2 ack ignored", dma_addr, m_addr);

    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule